// File: doc/BRIEF.md
# RMII receive frame sampler

This block turns the receive side of a reduced media-independent interface into a byte stream. It watches the combined carrier/data-valid line and the two receive data lines. It locks on to a frame through a fixed sequence: data-valid seen high, then the preamble on data bit 0, then the delimiter on data bit 1. After a short alignment wait it collects one di-bit per reference period and packs the di-bits into bytes.

The block runs from a clock at twice the 50 MHz reference rate. Its sample loop alternates a capture cycle with a cycle that tests data-valid, so it takes exactly one di-bit per reference period. The frame ends when the data-valid test finds the line low. A one-cycle end-of-packet pulse then reports whether the frame check sequence was intact. All PHY inputs cross two synchronizing flops before any decision uses them. Address filtering, frame storage, transmit and PHY management belong to neighbouring blocks.

Top module: `rmii_rx_sampler`

## Requirements
- R1: While reset is held, and in the cycles right after it, rx_valid_o, rx_last_o, eop_o and crc_ok_o are all low.
- R2: With data-valid low, activity on the receive data lines produces no byte and no end-of-packet pulse. Data-valid dropping before lock also returns the block to idle without output.
- R3: Lock needs data-valid high, then rxd bit 0 high, then rxd bit 1 high, in that order. A high on rxd bit 1 before bit 0 has been seen is ignored. The first data di-bit is the one that follows the di-bit in which rxd bit 1 first went high.
- R4: After lock and an alignment wait of ALIGN_CYC clocks, the block alternates a capture cycle and a data-valid test cycle. Each capture takes rxd[1:0] together as one di-bit.
- R5: Di-bits fill a byte least significant pair first: the first goes to bits [1:0] and the fourth to bits [7:6]. After every fourth di-bit, rx_valid_o is high for one cycle with that byte on rx_byte_o.
- R6: When the test cycle finds data-valid low, eop_o is high for exactly one cycle, three clocks after data-valid falls at the pins. If the frame ended on a byte boundary, the final byte comes out in that same cycle with rx_last_o high. No other byte carries rx_last_o.
- R7: A CRC-32 runs over every byte after the delimiter. It uses the reflected form of polynomial 0x04C11DB7 and starts from all ones. crc_ok_o is high with eop_o when the residue equals 0xDEBB20E3, and it keeps that value until the next lock.
- R8: A frame with any corrupted byte ends with crc_ok_o low, while its bytes and rx_last_o are still delivered.
- R9: If data-valid drops with one to three di-bits of an unfinished byte collected, that partial byte is discarded. No rx_last_o is given and crc_ok_o is low.
- R10: After every end-of-packet the block returns to waiting for data-valid, and the next frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, twice the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| crs_dv_i | input | 1 | Carrier-sense / data-valid from the PHY |
| rxd_i | input | 2 | Receive di-bit from the PHY |
| rx_byte_o | output | 8 | Assembled byte |
| rx_valid_o | output | 1 | rx_byte_o holds a new byte this cycle |
| rx_last_o | output | 1 | This byte is the final full byte of the frame |
| eop_o | output | 1 | One-cycle end-of-packet event |
| crc_ok_o | output | 1 | Frame check result, valid with eop_o and held until next lock |

## Verification
Each input the bench drives crosses two synchronizer flops before the state machine sees it. eop_o therefore rises exactly three clock edges after data-valid is driven low, and the bench checks that edge distance for every frame. A byte is due on the test cycle right after its fourth capture. The bench does not predict that cycle. A monitor sampling on the falling edge collects every valid byte, last flag and end-of-packet in order. Once each frame has ended and gone quiet, the collected stream is compared against the bytes driven and a CRC worked out bit by bit in the bench.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

  localparam int DIBIT_W        = 2;
  localparam int BYTE_W         = 8;
  localparam int PAIRS_PER_BYTE = BYTE_W / DIBIT_W;
  localparam int PAIR_CNT_W     = $clog2(PAIRS_PER_BYTE);

  localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_RF = 32'hEDB8_8320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_ALIGN,
    ST_SAMPLE,
    ST_CHECK
  } rx_state_e;

  // One byte through a right-shifting CRC-32 register, LSB first.
  function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                             input logic [BYTE_W-1:0] data);
    logic [31:0] c;
    c = crc_in ^ {24'd0, data};
    for (int k = 0; k < BYTE_W; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_RF) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rmii_rx_sync.sv
module rmii_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= in_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= g_stage[g-1].q;
      end
    end
  end

  assign out_o = g_stage[STAGES-1].q;

endmodule

// File: rtl/rmii_rx_ctrl.sv
module rmii_rx_ctrl
  import rmii_rx_pkg::*;
#(
  parameter int ALIGN_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dv_s,
  input  logic [DIBIT_W-1:0] rxd_s,
  output logic               sample_stb,
  output logic               check_stb,
  output logic               frame_start,
  output logic               frame_end
);

  localparam int CW = $clog2(ALIGN_CYC + 2);
  localparam logic [CW-1:0] ALIGN_LOAD = CW'(ALIGN_CYC > 0 ? ALIGN_CYC - 1 : 0);

  rx_state_e      state_q;
  logic [CW-1:0]  align_q;

  assign sample_stb  = (state_q == ST_SAMPLE);
  assign check_stb   = (state_q == ST_CHECK);
  assign frame_start = (state_q == ST_SFD) && dv_s && rxd_s[1];
  assign frame_end   = check_stb && !dv_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      align_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE:   if (dv_s) state_q <= ST_PRE;
        ST_PRE: begin
          if (!dv_s)         state_q <= ST_IDLE;
          else if (rxd_s[0]) state_q <= ST_SFD;
        end
        ST_SFD: begin
          if (!dv_s) begin
            state_q <= ST_IDLE;
          end else if (rxd_s[1]) begin
            state_q <= (ALIGN_CYC == 0) ? ST_SAMPLE : ST_ALIGN;
            align_q <= ALIGN_LOAD;
          end
        end
        ST_ALIGN: begin
          if (align_q == '0) state_q <= ST_SAMPLE;
          else               align_q <= align_q - CW'(1);
        end
        ST_SAMPLE: state_q <= ST_CHECK;
        ST_CHECK:  state_q <= dv_s ? ST_SAMPLE : ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rmii_rx_assemble.sv
module rmii_rx_assemble
  import rmii_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIBIT_W-1:0] rxd_s,
  input  logic               sample_stb,
  input  logic               check_stb,
  input  logic               frame_start,
  input  logic               frame_end,
  output logic [BYTE_W-1:0]  byte_o,
  output logic               valid_o,
  output logic               last_o,
  output logic               eop_o,
  output logic               crc_ok_o
);

  logic [BYTE_W-1:0]     sr_q;
  logic [PAIR_CNT_W-1:0] pair_q;
  logic                  full_q;
  logic [31:0]           crc_q;
  logic [31:0]           crc_upd;

  assign crc_upd = full_q ? crc32_step(crc_q, sr_q) : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      pair_q   <= '0;
      full_q   <= 1'b0;
      crc_q    <= CRC_INIT;
      byte_o   <= '0;
      valid_o  <= 1'b0;
      last_o   <= 1'b0;
      eop_o    <= 1'b0;
      crc_ok_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      eop_o   <= 1'b0;
      if (frame_start) begin
        pair_q   <= '0;
        full_q   <= 1'b0;
        crc_q    <= CRC_INIT;
        crc_ok_o <= 1'b0;
      end
      if (sample_stb) begin
        sr_q   <= {rxd_s, sr_q[BYTE_W-1:DIBIT_W]};
        pair_q <= pair_q + PAIR_CNT_W'(1);
        full_q <= (pair_q == PAIR_CNT_W'(PAIRS_PER_BYTE - 1));
      end
      if (check_stb) begin
        full_q <= 1'b0;
        crc_q  <= crc_upd;
        if (full_q) begin
          byte_o  <= sr_q;
          valid_o <= 1'b1;
          last_o  <= frame_end;
        end
        if (frame_end) begin
          eop_o    <= 1'b1;
          crc_ok_o <= (pair_q == '0) && (crc_upd == CRC_RESIDUE);
        end
      end
    end
  end

endmodule

// File: rtl/rmii_rx_sampler.sv
module rmii_rx_sampler
  import rmii_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ALIGN_CYC   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        crs_dv_i,
  input  logic [1:0]  rxd_i,
  output logic [7:0]  rx_byte_o,
  output logic        rx_valid_o,
  output logic        rx_last_o,
  output logic        eop_o,
  output logic        crc_ok_o
);

  logic               dv_s;
  logic [DIBIT_W-1:0] rxd_s;
  logic               sample_stb;
  logic               check_stb;
  logic               frame_start;
  logic               frame_end;

  rmii_rx_sync #(
    .W      (DIBIT_W + 1),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .in_i  ({crs_dv_i, rxd_i}),
    .out_o ({dv_s, rxd_s})
  );

  rmii_rx_ctrl #(
    .ALIGN_CYC (ALIGN_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .dv_s        (dv_s),
    .rxd_s       (rxd_s),
    .sample_stb  (sample_stb),
    .check_stb   (check_stb),
    .frame_start (frame_start),
    .frame_end   (frame_end)
  );

  rmii_rx_assemble u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxd_s       (rxd_s),
    .sample_stb  (sample_stb),
    .check_stb   (check_stb),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .byte_o      (rx_byte_o),
    .valid_o     (rx_valid_o),
    .last_o      (rx_last_o),
    .eop_o       (eop_o),
    .crc_ok_o    (crc_ok_o)
  );

endmodule

// File: rtl/rmii_rx_sampler_chk.sv
module rmii_rx_sampler_chk (
  input logic clk,
  input logic rst_n,
  input logic dv_s,
  input logic sample_stb,
  input logic check_stb,
  input logic frame_start,
  input logic rx_valid_o,
  input logic rx_last_o,
  input logic eop_o,
  input logic crc_ok_o
);

  AST_LOCK_AFTER_DV: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(dv_s)); // R3

  AST_CAPTURE_THEN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> check_stb); // R4

  AST_TEST_LOOPS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (check_stb && dv_s) |=> sample_stb); // R4

  AST_VALID_FROM_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(check_stb)); // R5

  AST_EOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |=> !eop_o); // R6

  AST_EOP_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |-> ($past(check_stb) && !$past(dv_s))); // R6

  AST_LAST_WITH_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_last_o |-> (eop_o && rx_valid_o)); // R6

  AST_CRC_SET_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_ok_o) |-> eop_o); // R7

endmodule

bind rmii_rx_sampler rmii_rx_sampler_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dv_s        (dv_s),
  .sample_stb  (sample_stb),
  .check_stb   (check_stb),
  .frame_start (frame_start),
  .rx_valid_o  (rx_valid_o),
  .rx_last_o   (rx_last_o),
  .eop_o       (eop_o),
  .crc_ok_o    (crc_ok_o)
);

// File: tb/rmii_rx_sampler_tb.sv
module rmii_rx_sampler_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       crs_dv_i = 1'b0;
  logic [1:0] rxd_i = 2'b00;
  logic [7:0] rx_byte_o;
  logic       rx_valid_o, rx_last_o, eop_o, crc_ok_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [7:0] tx [0:299];
  logic [7:0] mon_b [0:511];
  logic       mon_l [0:511];
  int mon_n = 0;
  int eop_n = 0;
  int eop_cyc = 0;
  logic eop_crc = 1'b0;
  int drop_cyc = 0;

  always #4 clk = ~clk;

  rmii_rx_sampler u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .crs_dv_i   (crs_dv_i),
    .rxd_i      (rxd_i),
    .rx_byte_o  (rx_byte_o),
    .rx_valid_o (rx_valid_o),
    .rx_last_o  (rx_last_o),
    .eop_o      (eop_o),
    .crc_ok_o   (crc_ok_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid_o && mon_n < 512) begin
        mon_b[mon_n] = rx_byte_o;
        mon_l[mon_n] = rx_last_o;
        mon_n = mon_n + 1;
      end
      if (eop_o) begin
        eop_n = eop_n + 1;
        eop_cyc = cyc;
        eop_crc = crc_ok_o;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bit-serial CRC: feedback of register LSB against each data bit.
  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ tx[i][b];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    return c;
  endfunction

  // Fill payload and append the frame check sequence; returns total bytes.
  function automatic int build(input int plen, input int kind);
    logic [31:0] f;
    for (int i = 0; i < plen; i++)
      tx[i] = (kind == 1) ? 8'(i) : 8'(i * 37 + plen * 11 + 5);
    f = ~ref_crc(plen);
    for (int k = 0; k < 4; k++) tx[plen + k] = f[8*k +: 8];
    return plen + 4;
  endfunction

  task automatic put_dibit(input logic [1:0] d);
    rxd_i = d;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input int nbytes, input int extra, input int flip, input int lead);
    mon_n = 0;
    eop_n = 0;
    if (flip >= 0) tx[flip] = tx[flip] ^ 8'h04;
    crs_dv_i = 1'b1;
    for (int i = 0; i < lead; i++) put_dibit(2'b10);
    for (int i = 0; i < 31; i++) put_dibit(2'b01);
    put_dibit(2'b11);
    for (int i = 0; i < nbytes; i++)
      for (int p = 0; p < 4; p++) put_dibit(tx[i][2*p +: 2]);
    for (int e = 0; e < extra; e++) put_dibit(2'(e + 1));
    crs_dv_i = 1'b0;
    rxd_i = 2'b00;
    drop_cyc = cyc;
    repeat (16) @(negedge clk);
  endtask

  task automatic verify(input string req, input int nbytes, input bit exp_ok,
                        input bit exp_last);
    check(mon_n == nbytes, req, "byte count", mon_n, nbytes);
    for (int i = 0; i < nbytes && i < mon_n; i++) begin
      check(mon_b[i] == tx[i], req, "byte value", mon_b[i], tx[i]);
      check(mon_l[i] == (exp_last && i == nbytes - 1), req, "last flag",
            mon_l[i], int'(exp_last && i == nbytes - 1));
    end
    check(eop_n == 1, "R6", "eop count", eop_n, 1);
    check(eop_cyc - drop_cyc == 3, "R6", "eop latency", eop_cyc - drop_cyc, 3);
    check(eop_crc == exp_ok, req, "crc_ok", eop_crc, exp_ok);
  endtask

  initial begin
    int nb;
    repeat (3) @(negedge clk);
    check(!rx_valid_o && !rx_last_o && !eop_o && !crc_ok_o, "R1", "outputs in reset",
          {rx_valid_o, rx_last_o, eop_o, crc_ok_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!rx_valid_o && !eop_o && !crc_ok_o, "R1", "outputs after reset",
          {rx_valid_o, eop_o, crc_ok_o}, 0);

    // R2: line noise without data-valid, then a false carrier.
    mon_n = 0;
    eop_n = 0;
    for (int i = 0; i < 40; i++) begin
      rxd_i = 2'(i * 3 + 1);
      @(negedge clk);
    end
    crs_dv_i = 1'b1;
    rxd_i = 2'b00;
    repeat (6) @(negedge clk);
    rxd_i = 2'b01;
    repeat (4) @(negedge clk);
    crs_dv_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      rxd_i = 2'(i);
      @(negedge clk);
    end
    rxd_i = 2'b00;
    repeat (8) @(negedge clk);
    check(mon_n == 0, "R2", "bytes while idle", mon_n, 0);
    check(eop_n == 0, "R2", "eop while idle", eop_n, 0);

    // R5 R7 R10: good frames over a sweep of lengths, back to back.
    for (int len = 0; len <= 12; len++) begin
      nb = build(len, 0);
      send(nb, 0, -1, 0);
      verify("R7", nb, 1'b1, 1'b1);
    end

    // R5: every byte value once, least significant di-bit first.
    nb = build(256, 1);
    send(nb, 0, -1, 0);
    verify("R5", nb, 1'b1, 1'b1);

    // R3: early highs on rxd bit 1 before the preamble must not lock.
    nb = build(20, 0);
    send(nb, 0, -1, 3);
    verify("R3", nb, 1'b1, 1'b1);

    // R8: one corrupted byte at each position.
    for (int f = 0; f < 10; f++) begin
      nb = build(6, 0);
      send(nb, 0, f, 0);
      verify("R8", nb, 1'b0, 1'b1);
    end

    // R9: one to three stray di-bits after the last full byte.
    for (int e = 1; e <= 3; e++) begin
      nb = build(5, 0);
      send(nb, e, -1, 0);
      verify("R9", nb, 1'b0, 1'b0);
    end

    // R10: a clean frame right after the broken ones.
    nb = build(9, 0);
    send(nb, 0, -1, 0);
    verify("R10", nb, 1'b1, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule